// File: doc/BRIEF.md
# Signed Array Multiplier with Magnitude Complementers

This block multiplies two signed two's-complement operands entirely in combinational logic. Each operand has MAG_W magnitude bits and a sign bit in its top position. A conditional two's complementer turns each negative operand into its positive magnitude. An unsigned array of AND gates and ripple full-adder rows then forms the product of the two magnitudes. A third conditional complementer gives the result a negative value again when exactly one operand is negative.

Each complementer uses a bitwise rule that needs no adder. It copies every bit from the least significant end up to and including the lowest set bit, and it inverts every bit above that one. When its enable is low it passes the input through unchanged.

The outputs are a product field that is twice MAG_W bits wide and a separate product sign bit. There is no clock and no state, so the outputs follow the inputs after the propagation delay of the array.

Top module: `sm_array_mult`

## Requirements
- R1: For every pair of operands, prod_o equals the low 2*MAG_W bits of the true signed product. Each operand is read as a (MAG_W+1)-bit two's-complement number whose bit MAG_W is the sign.
- R2: sign_o is 1 exactly when one operand has its sign bit set and the other does not. This holds even when the product is zero.
- R3: An operand equal to the most negative value, -2^MAG_W, gives the correct result. Its magnitude 2^MAG_W needs MAG_W+1 bits. For MAG_W=5, -32 times 1 gives prod_o = 992 with sign_o = 1, and -32 times -1 gives prod_o = 32 with sign_o = 0.
- R4: When both operands equal the most negative value, prod_o is 0 and sign_o is 0, because 2^(2*MAG_W) wraps to zero in the product field.
- R5: A zero operand gives prod_o = 0. sign_o still follows the sign bits, so 0 times -5 gives sign_o = 1.
- R6: When both operands are non-negative, no complement is applied. prod_o is the plain unsigned product and sign_o is 0, for example 31 times 31 gives 961.
- R7: The block holds no state. The outputs depend only on the present inputs and change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | MAG_W+1 | Multiplicand, two's complement, sign in bit MAG_W |
| b_i | input | MAG_W+1 | Multiplier, two's complement, sign in bit MAG_W |
| prod_o | output | 2*MAG_W | Low 2*MAG_W bits of the signed product |
| sign_o | output | 1 | Product sign, the XOR of the two operand signs |

## Verification
The hardest case is an operand at the most negative value. Its complement is the same bit pattern, and its magnitude exists only in the extra top bit of the widened core, so a core sized for MAG_W bits would silently lose it. Both most-negative operands together push the true product just past the product field. The bench drives both cases from the vector table. It also sweeps all 4096 operand pairs at MAG_W=5, which reaches every combination of signs, of zero operands and of the most negative value. The rule of copying bits up to the first 1 depends on where that 1 sits, and the sweep places the lowest set bit of every magnitude at every position.

// File: rtl/smm_pkg.sv
package smm_pkg;
   function automatic int prod_width(input int mag_w);
      return 2 * mag_w;
   endfunction

   function automatic int core_width(input int mag_w);
      return mag_w + 1;
   endfunction
endpackage

// File: rtl/smm_fa.sv
module smm_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic hx;
   assign hx  = x_i ^ y_i;
   assign s_o = hx ^ c_i;
   assign c_o = (x_i & y_i) | (hx & c_i);
endmodule

// File: rtl/smm_cond_neg.sv
module smm_cond_neg #(
   parameter int W = 6
) (
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] seen;

   generate
      if (W < 1) begin : g_bad
         $error("smm_cond_neg: W must be at least 1");
      end
   endgenerate

   assign seen[0] = 1'b0;
   assign q_o[0]  = d_i[0];

   genvar i;
   generate
      for (i = 1; i < W; i++) begin : g_bit
         assign seen[i] = seen[i-1] | d_i[i-1];
         assign q_o[i]  = d_i[i] ^ (en_i & seen[i]);
      end
   endgenerate
endmodule

// File: rtl/smm_core.sv
module smm_core #(
   parameter int W = 6
) (
   input  logic [W-1:0]   x_i,
   input  logic [W-1:0]   y_i,
   output logic [2*W-1:0] p_o
);
   logic [W-1:0][W-1:0] pp;
   logic [W-1:0][W:0]   row_s;

   generate
      if (W < 2) begin : g_bad
         $error("smm_core: W must be at least 2");
      end
   endgenerate

   genvar r, c;
   generate
      for (r = 0; r < W; r++) begin : g_pp_row
         for (c = 0; c < W; c++) begin : g_pp_col
            assign pp[r][c] = x_i[c] & y_i[r];
         end
      end

      for (r = 0; r < W; r++) begin : g_row
         if (r == 0) begin : g_first
            assign row_s[0] = {1'b0, pp[0]};
         end else begin : g_add
            logic [W:0] cy;
            assign cy[0] = 1'b0;
            for (c = 0; c < W; c++) begin : g_cell
               smm_fa u_fa (
                  .x_i (row_s[r-1][c+1]),
                  .y_i (pp[r][c]),
                  .c_i (cy[c]),
                  .s_o (row_s[r][c]),
                  .c_o (cy[c+1])
               );
            end
            assign row_s[r][W] = cy[W];
         end
         assign p_o[r] = row_s[r][0];
      end
   endgenerate

   assign p_o[2*W-1:W] = row_s[W-1][W:1];
endmodule

// File: rtl/sm_array_mult.sv
module sm_array_mult #(
   parameter int MAG_W = 5
) (
   input  logic [MAG_W:0]     a_i,
   input  logic [MAG_W:0]     b_i,
   output logic [2*MAG_W-1:0] prod_o,
   output logic               sign_o
);
   localparam int W  = smm_pkg::core_width(MAG_W);
   localparam int PW = smm_pkg::prod_width(MAG_W);

   generate
      if (MAG_W < 1) begin : g_bad
         $error("sm_array_mult: MAG_W must be at least 1");
      end
   endgenerate

   logic         a_neg, b_neg;
   logic [W-1:0] a_mag, b_mag;
   logic [2*W-1:0] core_p;
   logic         unused_core_hi;

   assign a_neg  = a_i[MAG_W];
   assign b_neg  = b_i[MAG_W];
   assign sign_o = a_neg ^ b_neg;

   smm_cond_neg #(.W(W)) u_neg_a (
      .en_i (a_neg),
      .d_i  (a_i),
      .q_o  (a_mag)
   );

   smm_cond_neg #(.W(W)) u_neg_b (
      .en_i (b_neg),
      .d_i  (b_i),
      .q_o  (b_mag)
   );

   smm_core #(.W(W)) u_core (
      .x_i (a_mag),
      .y_i (b_mag),
      .p_o (core_p)
   );

   smm_cond_neg #(.W(PW)) u_neg_p (
      .en_i (sign_o),
      .d_i  (core_p[PW-1:0]),
      .q_o  (prod_o)
   );

   assign unused_core_hi = |core_p[2*W-1:PW];
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
   parameter int MAG_W = 5
) (
   input logic [MAG_W:0]     a_i,
   input logic [MAG_W:0]     b_i,
   input logic [2*MAG_W-1:0] prod_o,
   input logic               sign_o,
   input logic [MAG_W:0]     a_mag,
   input logic [MAG_W:0]     b_mag
);
   localparam int W  = MAG_W + 1;
   localparam int PW = 2 * MAG_W;
   localparam logic [MAG_W:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

   logic signed [2*W-1:0] ax, bx;
   logic [PW-1:0]         ref_p;

   assign ax    = {{W{a_i[MAG_W]}}, a_i};
   assign bx    = {{W{b_i[MAG_W]}}, b_i};
   assign ref_p = PW'(ax * bx);

   always_comb begin
      // R1: product field matches the signed product modulo 2^(2*MAG_W)
      a_r1_prod_match: assert (prod_o == ref_p);
      // R2: both signs clear gives a clear product sign
      if (!a_i[MAG_W] && !b_i[MAG_W]) a_r2_pos_sign: assert (!sign_o);
      // R2: exactly one negative operand gives a set product sign
      if (a_i[MAG_W] != b_i[MAG_W]) a_r2_mixed_sign: assert (sign_o);
      // R3: a magnitude uses its top bit only for 2^MAG_W
      a_r3_mag_range: assert (!a_mag[MAG_W] || (a_mag[MAG_W-1:0] == '0));
      a_r3_mag_range_b: assert (!b_mag[MAG_W] || (b_mag[MAG_W-1:0] == '0));
      // R4: two most-negative operands wrap to zero
      if (a_i == MOST_NEG && b_i == MOST_NEG) a_r4_both_min: assert (prod_o == '0 && !sign_o);
      // R5: a zero operand forces a zero product field
      if (a_i == '0 || b_i == '0) a_r5_zero_operand: assert (prod_o == '0);
      // R6: non-negative operands reach the core unchanged
      if (!a_i[MAG_W]) a_r6_pass_a: assert (a_mag == a_i);
      if (!b_i[MAG_W]) a_r6_pass_b: assert (b_mag == b_i);
   end
endmodule

bind sm_array_mult smm_checker #(.MAG_W(MAG_W)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .prod_o (prod_o),
   .sign_o (sign_o),
   .a_mag  (a_mag),
   .b_mag  (b_mag)
);

// File: tb/sm_array_mult_tb.sv
module sm_array_mult_tb;
   localparam int N  = 5;
   localparam int OW = N + 1;
   localparam int PW = 2 * N;

   typedef struct packed {
      logic [OW-1:0] a;
      logic [OW-1:0] b;
      logic [PW-1:0] p;
      logic          s;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{6'h00, 6'h00, 10'd0,   1'b0},  // R6 all zero
      '{6'h0D, 6'h0B, 10'd143, 1'b0},  // R6 13*11
      '{6'h1F, 6'h1F, 10'd961, 1'b0},  // R6 31*31
      '{6'h20, 6'h01, 10'd992, 1'b1},  // R3 -32*1
      '{6'h20, 6'h1F, 10'd32,  1'b1},  // R3 -32*31
      '{6'h20, 6'h3F, 10'd32,  1'b0},  // R3 -32*-1
      '{6'h20, 6'h20, 10'd0,   1'b0},  // R4 -32*-32
      '{6'h00, 6'h3B, 10'd0,   1'b1},  // R5 0*-5
      '{6'h3F, 6'h3F, 10'd1,   1'b0},  // R1 -1*-1
      '{6'h33, 6'h0B, 10'd881, 1'b1},  // R1 -13*11
      '{6'h07, 6'h37, 10'd961, 1'b1},  // R1 7*-9
      '{6'h21, 6'h21, 10'd961, 1'b0}   // R1 -31*-31
   };

   logic          clk = 1'b0;
   logic [OW-1:0] a_i = '0;
   logic [OW-1:0] b_i = '0;
   logic [PW-1:0] prod_o;
   logic          sign_o;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   sm_array_mult #(.MAG_W(N)) u_dut (
      .a_i    (a_i),
      .b_i    (b_i),
      .prod_o (prod_o),
      .sign_o (sign_o)
   );

   task automatic chk(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h actual=%0d expected=%0d", tag, a_i, b_i, got, exp);
      end
   endtask

   task automatic apply(input logic [OW-1:0] a, input logic [OW-1:0] b);
      @(negedge clk);
      a_i = a;
      b_i = b;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // R6 idle state: zero operands
      #1;
      chk("R6 idle product", prod_o, '0);
      chk("R6 idle sign", {{(PW-1){1'b0}}, sign_o}, '0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         apply(VEC[k].a, VEC[k].b);
         chk("R1 table product", prod_o, VEC[k].p);
         chk("R2 table sign", {{(PW-1){1'b0}}, sign_o}, {{(PW-1){1'b0}}, VEC[k].s});
      end

      // R7: outputs follow inputs with no clock edge
      @(negedge clk);
      a_i = 6'h0D; b_i = 6'h0B; #1;
      chk("R7 no-clock update 143", prod_o, 10'd143);
      a_i = 6'h33; #1;
      chk("R7 no-clock update 881", prod_o, 10'd881);
      a_i = 6'h0D; #1;
      chk("R7 return to 143", prod_o, 10'd143);

      // R1 R2 R3 R4 R5 exhaustive sweep
      for (int i = -32; i < 32; i++) begin
         for (int j = -32; j < 32; j++) begin
            logic [PW-1:0] ep;
            logic          es;
            ep = PW'(i * j);
            es = (i < 0) ^ (j < 0);
            apply(OW'(i), OW'(j));
            chk("R1 sweep product", prod_o, ep);
            chk("R2 sweep sign", {{(PW-1){1'b0}}, sign_o}, {{(PW-1){1'b0}}, es});
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule